// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates five maskable request sources for a small microcontroller core: two external request lines, two timer overflow events and one serial source whose pending state is the OR of a receive flag and a transmit flag. Software configures it through a synchronous write port with two strobes, one loading the enable register and one loading the level register. The enable register holds one bit per source plus a master bit. The level register holds one bit per source that places it in the upper or the lower tier.

Each cycle the controller picks one candidate. An upper-tier request beats any lower-tier one, and between requests in the same tier a fixed scan order decides. The controller also keeps one busy flag per tier. A candidate is offered to the CPU only when no handler of its own tier or above is busy. An offer is a one-cycle strobe with a 16-bit entry address, and the entry address stays on the bus afterwards. When the CPU acknowledges, the controller marks the tier busy and drops the accepted event flag, except for the serial flags, which only software clears. A return pulse frees the uppermost busy tier.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the strobe is 0, the entry bus reads 0000h, and the enable and level registers are all zero, so no event is offered until software enables it.
- R2: The master enable is bit 7 of the enable register. While it is 0, no strobe is raised, whatever the per-source bits hold.
- R3: Enable bits 0 to 4 gate external 0, timer 0, external 1, timer 1 and serial respectively. A pending source whose bit is 0 is never offered. Level register bits 0 to 4 use the same map, and 1 means upper tier.
- R4: The entry addresses are 0003h (external 0), 000Bh (timer 0), 0013h (external 1), 001Bh (timer 1) and 0023h (serial).
- R5: Among pending requests of one tier, the first in the scan order external 0, timer 0, external 1, timer 1, serial is offered.
- R6: An upper-tier request is offered ahead of every lower-tier request, regardless of scan position.
- R7: While a lower-tier handler is busy, an upper-tier request is still offered (preemption), but another lower-tier request is not. While an upper-tier handler is busy, nothing is offered.
- R8: The strobe lasts exactly one cycle, rises one clock after the event flag is captured, and no further strobe is raised until the CPU acknowledges. An acknowledge with no offer outstanding has no effect.
- R9: The acknowledge clears the accepted external or timer flag. A new event for that same source in the acknowledge cycle is kept.
- R10: The serial request is pending while either its receive or its transmit flag is set (set inputs bit 0 and bit 1). The acknowledge leaves these flags set. Only the matching clear input removes one, and a set in the same cycle wins over the clear.
- R11: A return pulse frees the upper tier if it is busy, and otherwise the lower tier. A pending request blocked by the freed tier is then offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ie_we_i | input | 1 | Write strobe for the enable register |
| ip_we_i | input | 1 | Write strobe for the level register |
| wdata_i | input | 8 | Write data for either register |
| src_set_i | input | 4 | One-cycle event pulses: external 0, timer 0, external 1, timer 1 (bits 0..3) |
| ser_set_i | input | 2 | Serial receive (bit 0) and transmit (bit 1) event pulses |
| ser_clr_i | input | 2 | Software clear for the serial receive (bit 0) and transmit (bit 1) flags |
| irq_ack_i | input | 1 | CPU acknowledge of the outstanding offer |
| irq_ret_i | input | 1 | Return-from-handler pulse |
| irq_req_o | output | 1 | One-cycle offer strobe to the CPU |
| irq_vec_o | output | 16 | Entry address of the latest offer |

## Verification
Two things can land on the same clock edge. The acknowledge of an outstanding offer can come in the same cycle as a fresh event on the source being cleared, and a return pulse can free a tier while a blocked request is waiting. The bench drives the acknowledge and the new event in one cycle, then returns and expects a second offer with the same entry address. It also stacks a lower-tier and an upper-tier handler with blocked requests in both tiers, and checks that each return releases exactly the requests its tier was holding back.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned IDX_W = $clog2(NSRC);

  typedef enum logic {
    TIER_LO = 1'b0,
    TIER_HI = 1'b1
  } tier_e;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
    tier_e            tier;
  } cand_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) shift_q <= '0;
    else          shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = shift_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ie_we_i,
  input  logic              ip_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   src_en_o,
  output logic              master_en_o,
  output logic [NSRC-1:0]   src_hi_o
);
  localparam int unsigned MASTER_BIT = DATA_W - 1;

  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] hi_q, hi_d;
  logic            mst_q, mst_d;
  logic            unused_wbits;

  assign unused_wbits = ^wdata_i[MASTER_BIT-1:NSRC];

  always_comb begin
    en_d  = en_q;
    mst_d = mst_q;
    hi_d  = hi_q;
    if (ie_we_i) begin
      en_d  = wdata_i[NSRC-1:0];
      mst_d = wdata_i[MASTER_BIT];
    end
    if (ip_we_i) begin
      hi_d = wdata_i[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      mst_q <= 1'b0;
      hi_q  <= '0;
    end else begin
      en_q  <= en_d;
      mst_q <= mst_d;
      hi_q  <= hi_d;
    end
  end

  assign src_en_o    = en_q;
  assign master_en_o = mst_q;
  assign src_hi_o    = hi_q;

  // R1: configuration only changes through a write strobe
  a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_we_i && !ip_we_i) |=> ($stable(en_q) && $stable(hi_q) && $stable(mst_q)));
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-2:0] set_i,
  input  logic [NSRC-2:0] ack_clr_i,
  input  logic [1:0]      ser_set_i,
  input  logic [1:0]      ser_clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-2:0] evt_q, evt_d;
  logic [1:0]      ser_q, ser_d;

  for (genvar g = 0; g < NSRC - 1; g++) begin : g_evt
    always_comb begin
      evt_d[g] = evt_q[g];
      if (ack_clr_i[g]) evt_d[g] = 1'b0;
      if (set_i[g])     evt_d[g] = 1'b1;
    end

    // R9: an event in the acknowledge cycle survives the clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[g] && ack_clr_i[g]) |=> pend_o[g]);
  end

  for (genvar s = 0; s < 2; s++) begin : g_ser
    always_comb begin
      ser_d[s] = ser_q[s];
      if (ser_clr_i[s]) ser_d[s] = 1'b0;
      if (ser_set_i[s]) ser_d[s] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      ser_q <= '0;
    end else begin
      evt_q <= evt_d;
      ser_q <= ser_d;
    end
  end

  assign pend_o = {|ser_q, evt_q};

  // R10: the serial request stays pending until software clears a flag
  a_r10_ser_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o[NSRC-1] && (ser_clr_i == 2'b00)) |=> pend_o[NSRC-1]);
endmodule

// File: rtl/irq_cand_pick.sv
module irq_cand_pick
  import irq_nest_pkg::*;
#(
  parameter int unsigned NSRC = 5
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            master_i,
  input  logic [NSRC-1:0] hi_i,
  output cand_t           cand_o
);
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  req_hi;
  logic [NSRC-1:0]  req_lo;
  logic [IDX_W-1:0] idx_hi;
  logic [IDX_W-1:0] idx_lo;

  assign req    = pend_i & en_i & {NSRC{master_i}};
  assign req_hi = req & hi_i;
  assign req_lo = req & ~hi_i;

  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_hi[i]) idx_hi = IDX_W'(i);
      if (req_lo[i]) idx_lo = IDX_W'(i);
    end
  end

  always_comb begin
    cand_o.valid = |req;
    cand_o.tier  = (|req_hi) ? TIER_HI : TIER_LO;
    cand_o.idx   = (|req_hi) ? idx_hi : idx_lo;
  end
endmodule

// File: rtl/irq_tier_track.sv
module irq_tier_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_lo_i,
  input  logic mark_hi_i,
  input  logic ret_i,
  output logic busy_lo_o,
  output logic busy_hi_o
);
  logic lo_q, lo_d;
  logic hi_q, hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (ret_i) begin
      if (hi_q) hi_d = 1'b0;
      else      lo_d = 1'b0;
    end
    if (mark_hi_i) hi_d = 1'b1;
    if (mark_lo_i) lo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= 1'b0;
      hi_q <= 1'b0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign busy_lo_o = lo_q;
  assign busy_hi_o = hi_q;

  // R11: a return frees the upper tier first and leaves the lower tier alone
  a_r11_ret_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && hi_q && !mark_hi_i && !mark_lo_i) |=> (!busy_hi_o && $stable(busy_lo_o)));

  // R11: with the upper tier idle, a return frees the lower tier
  a_r11_ret_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !hi_q && !mark_hi_i && !mark_lo_i) |=> (!busy_lo_o && !busy_hi_o));
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned VEC_BASE = 3,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ie_we_i,
  input  logic              ip_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-2:0]   src_set_i,
  input  logic [1:0]        ser_set_i,
  input  logic [1:0]        ser_clr_i,
  input  logic              irq_ack_i,
  input  logic              irq_ret_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic             rst_n_s;
  logic [NSRC-1:0]  src_en;
  logic [NSRC-1:0]  src_hi;
  logic             master_en;
  logic [NSRC-1:0]  pend;
  cand_t            cand;
  logic             busy_lo, busy_hi;
  logic             allow, issue, take;
  logic [NSRC-2:0]  ack_clr;

  logic             wait_q, wait_d;
  logic             req_q, req_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  tier_e            tier_q, tier_d;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  irq_cfg_regs #(.NSRC(NSRC), .DATA_W(DATA_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .ie_we_i     (ie_we_i),
    .ip_we_i     (ip_we_i),
    .wdata_i     (wdata_i),
    .src_en_o    (src_en),
    .master_en_o (master_en),
    .src_hi_o    (src_hi)
  );

  irq_src_flags #(.NSRC(NSRC)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .set_i     (src_set_i),
    .ack_clr_i (ack_clr),
    .ser_set_i (ser_set_i),
    .ser_clr_i (ser_clr_i),
    .pend_o    (pend)
  );

  irq_cand_pick #(.NSRC(NSRC)) u_pick (
    .pend_i   (pend),
    .en_i     (src_en),
    .master_i (master_en),
    .hi_i     (src_hi),
    .cand_o   (cand)
  );

  irq_tier_track u_tier (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .mark_lo_i (take && (tier_q == TIER_LO)),
    .mark_hi_i (take && (tier_q == TIER_HI)),
    .ret_i     (irq_ret_i),
    .busy_lo_o (busy_lo),
    .busy_hi_o (busy_hi)
  );

  function automatic logic [VEC_W-1:0] entry_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
  endfunction

  // an upper candidate waits only for a busy upper tier; a lower one for either
  always_comb begin
    if (cand.tier == TIER_HI) allow = cand.valid && !busy_hi;
    else                      allow = cand.valid && !busy_hi && !busy_lo;
  end

  assign issue = allow && !wait_q;
  assign take  = wait_q && irq_ack_i;

  for (genvar g = 0; g < NSRC - 1; g++) begin : g_clr
    assign ack_clr[g] = take && (sel_q == IDX_W'(g));
  end

  always_comb begin
    wait_d = wait_q;
    req_d  = 1'b0;
    vec_d  = vec_q;
    sel_d  = sel_q;
    tier_d = tier_q;
    if (issue) begin
      wait_d = 1'b1;
      req_d  = 1'b1;
      vec_d  = entry_of(cand.idx);
      sel_d  = cand.idx;
      tier_d = cand.tier;
    end else if (take) begin
      wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wait_q <= 1'b0;
      req_q  <= 1'b0;
      vec_q  <= '0;
      sel_q  <= '0;
      tier_q <= TIER_LO;
    end else begin
      wait_q <= wait_d;
      req_q  <= req_d;
      vec_q  <= vec_d;
      sel_q  <= sel_d;
      tier_q <= tier_d;
    end
  end

  assign irq_req_o = req_q;
  assign irq_vec_o = vec_q;

  // R8: the strobe is a single cycle wide
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req_o |=> !irq_req_o);

  // R8: no second offer while the first is unacknowledged
  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wait_q && !irq_ack_i) |=> !irq_req_o);

  // R2: an offer implies the master enable was set
  a_r2_master: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req_o |-> $past(master_en));

  // R7: an upper offer never lands on a busy upper tier
  a_r7_upper_free: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_req_o && tier_q == TIER_HI) |-> !$past(busy_hi));

  // R7: a lower offer needs both tiers idle
  a_r7_lower_free: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_req_o && tier_q == TIER_LO) |-> (!$past(busy_hi) && !$past(busy_lo)));

  // R4: every offered entry sits on the address grid
  a_r4_entry_grid: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_req_o |-> ((int'(irq_vec_o) - VEC_BASE) % VEC_STEP == 0
                   && int'(irq_vec_o) <= VEC_BASE + VEC_STEP * (NSRC - 1)));
endmodule

// File: tb/irq_nest_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        ie_we, ip_we;
  logic [7:0]  wdata;
  logic [3:0]  src_set;
  logic [1:0]  ser_set, ser_clr;
  logic        ack, ret;
  logic        req;
  logic [15:0] vec;

  int checks = 0;
  int fails  = 0;

  irq_nest_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ie_we_i   (ie_we),
    .ip_we_i   (ip_we),
    .wdata_i   (wdata),
    .src_set_i (src_set),
    .ser_set_i (ser_set),
    .ser_clr_i (ser_clr),
    .irq_ack_i (ack),
    .irq_ret_i (ret),
    .irq_req_o (req),
    .irq_vec_o (vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // fields: enable[38:31] level[30:23] set[22:19] serial[18:17] expect_req[16] expect_vec[15:0]
  localparam int NVEC = 12;
  localparam logic [38:0] TBL [NVEC] = '{
    {8'h9F, 8'h00, 4'hF, 2'b00, 1'b1, 16'h0003},  // R5 all low, first wins
    {8'h9F, 8'h00, 4'hE, 2'b00, 1'b1, 16'h000B},  // R5
    {8'h9F, 8'h00, 4'hC, 2'b00, 1'b1, 16'h0013},  // R5
    {8'h9F, 8'h00, 4'h8, 2'b00, 1'b1, 16'h001B},  // R4
    {8'h9F, 8'h00, 4'h0, 2'b01, 1'b1, 16'h0023},  // R4 serial
    {8'h1F, 8'h00, 4'hF, 2'b11, 1'b0, 16'h0000},  // R2 master off
    {8'h9E, 8'h00, 4'h1, 2'b00, 1'b0, 16'h0000},  // R3 source masked
    {8'h9F, 8'h10, 4'hF, 2'b10, 1'b1, 16'h0023},  // R6 serial upper
    {8'h9F, 8'h08, 4'h9, 2'b00, 1'b1, 16'h001B},  // R6
    {8'h9F, 8'h0A, 4'hA, 2'b00, 1'b1, 16'h000B},  // R5 within upper
    {8'h8C, 8'h00, 4'hF, 2'b00, 1'b1, 16'h0013},  // R3 partial mask
    {8'h9F, 8'h1F, 4'h6, 2'b00, 1'b1, 16'h000B}   // R5 all upper
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ie_we = 0; ip_we = 0; wdata = '0;
    src_set = '0; ser_set = '0; ser_clr = '0; ack = 0; ret = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_ie(input logic [7:0] d);
    ie_we = 1'b1; wdata = d; @(negedge clk); ie_we = 1'b0;
  endtask

  task automatic wr_ip(input logic [7:0] d);
    ip_we = 1'b1; wdata = d; @(negedge clk); ip_we = 1'b0;
  endtask

  task automatic pulse_src(input logic [3:0] s, input logic [1:0] r);
    src_set = s; ser_set = r; @(negedge clk); src_set = '0; ser_set = '0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; @(negedge clk); ret = 1'b0;
  endtask

  task automatic wait_strobe(input int lim, output logic seen, output logic [15:0] v);
    seen = 1'b0; v = '0;
    for (int k = 0; k < lim && !seen; k++) begin
      @(negedge clk);
      if (req) begin seen = 1'b1; v = vec; end
    end
  endtask

  task automatic expect_offer(input logic [15:0] ev, input string tag);
    logic s; logic [15:0] v;
    wait_strobe(6, s, v);
    chk(s && v == ev, tag, {15'd0, s, v}, {16'd1, ev});
  endtask

  task automatic expect_none(input string tag);
    logic s; logic [15:0] v;
    wait_strobe(6, s, v);
    chk(!s, tag, {31'd0, s}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk(req == 1'b0, "R1 strobe low after reset", {31'd0, req}, 32'd0);
    chk(vec == 16'h0000, "R1 entry bus after reset", {16'd0, vec}, 32'd0);
    pulse_src(4'hF, 2'b11);
    expect_none("R1 nothing enabled after reset");

    // table walk
    for (int n = 0; n < NVEC; n++) begin
      logic s; logic [15:0] v;
      do_reset();
      wr_ie(TBL[n][38:31]);
      wr_ip(TBL[n][30:23]);
      pulse_src(TBL[n][22:19], TBL[n][18:17]);
      wait_strobe(6, s, v);
      chk(s == TBL[n][16] && (!s || v == TBL[n][15:0]), $sformatf("R3/R5/R6 table entry %0d", n),
          {15'd0, s, v}, {15'd0, TBL[n][16], TBL[n][15:0]});
    end

    // R8 strobe width, hold-off, stray acknowledge
    do_reset();
    pulse_ack();
    wr_ie(8'h81);
    pulse_src(4'h1, 2'b00);
    expect_offer(16'h0003, "R8 stray ack ignored");
    @(negedge clk);
    chk(req == 1'b0, "R8 strobe one cycle", {31'd0, req}, 32'd0);
    expect_none("R8 no repeat before ack");
    pulse_ack();
    pulse_ret();
    expect_none("R9 ack cleared external 0");

    // R9 new event in acknowledge cycle
    do_reset();
    wr_ie(8'h81);
    pulse_src(4'h1, 2'b00);
    expect_offer(16'h0003, "R9 first offer");
    ack = 1'b1; src_set = 4'h1;
    @(negedge clk);
    ack = 1'b0; src_set = '0;
    pulse_ret();
    expect_offer(16'h0003, "R9 set wins over ack clear");

    // R7 / R11 nesting
    do_reset();
    wr_ie(8'h8F);
    wr_ip(8'h0A);
    pulse_src(4'h1, 2'b00);
    expect_offer(16'h0003, "R7 lower handler enters");
    pulse_ack();
    pulse_src(4'h4, 2'b00);
    expect_none("R7 lower blocked by busy lower");
    pulse_src(4'h8, 2'b00);
    expect_offer(16'h001B, "R7 upper preempts lower");
    pulse_ack();
    pulse_src(4'h2, 2'b00);
    expect_none("R7 upper blocked by busy upper");
    pulse_ret();
    expect_offer(16'h000B, "R11 return frees upper");
    pulse_ack();
    pulse_ret();
    expect_none("R11 lower still busy");
    pulse_ret();
    expect_offer(16'h0013, "R11 return frees lower");
    pulse_ack();
    pulse_ret();

    // R10 serial flags
    do_reset();
    wr_ie(8'h90);
    pulse_src(4'h0, 2'b01);
    expect_offer(16'h0023, "R10 receive flag offers");
    pulse_ack();
    pulse_ret();
    expect_offer(16'h0023, "R10 ack keeps serial flag");
    pulse_ack();
    ser_clr = 2'b01; @(negedge clk); ser_clr = 2'b00;
    pulse_ret();
    expect_none("R10 software clear removes flag");
    ser_clr = 2'b10; ser_set = 2'b10; @(negedge clk); ser_clr = 2'b00; ser_set = 2'b00;
    expect_offer(16'h0023, "R10 transmit set wins over clear");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule